// File: doc/BRIEF.md
# Multi-lane deterministic release buffer

This block sits on the receive side of a multi-lane converter link, after each lane's frames have been recovered and aligned. Every lane has an elastic FIFO. A lane starts storing one frame per frame clock from the cycle that carries its start-of-data marker. A local multiframe counter of K frames is zeroed by an external alignment pulse. This gives the receiver the same time base as the transmitter.

The block does not release data when the last lane shows up. It waits for a fixed release point, which lies a programmable number of frames after a multiframe boundary. At that point every lane begins to stream out on the same clock, one frame per cycle. The latency from the alignment reference to the output therefore does not depend on when the lanes happen to arrive. The block also reports the position within the multiframe at which the last lane arrived, so that software can choose a release offset with margin. It reports two sticky errors: FIFO overflow, and an alignment pulse whose phase disagrees with the running counter.

Top module: `lane_release_buffer`

## Requirements
- R1: After reset, `ready`, `overflow` and `align_err` are 0 and `last_arrival` is 0.
- R2: The multiframe counter reads 0 in the cycle after the first alignment pulse and counts 0..K-1 cyclically from there. No release happens before the first alignment pulse.
- R3: The release position is `rbd` for 1 <= `rbd` < K, and 0 for `rbd` = K or any value outside 1..K. The release edge is the first clock edge at which the counter equals that position and all lanes were already captured before that cycle. A last lane whose marker is sampled at or after the position slips one multiframe. `ready` rises after that edge and stays high.
- R4: From the cycle `ready` rises, the lane i field `out_data[i*DW +: DW]` shows that lane's frames in order, starting with the frame that carried its marker. All lanes advance together, one frame per cycle.
- R5: `last_arrival` holds the counter value of the cycle in which the final lane's marker was sampled. It is visible from the next cycle.
- R6: A write to a lane FIFO that already holds DEPTH frames is dropped and sets `overflow`. The flag stays set until reset.
- R7: An alignment pulse after the first one that is sampled when the counter is not at K-1 sets `align_err` until reset. It does not move the counter, so the output stream continues unchanged.
- R8: If any lane that has seen its marker has `lane_valid` low, all FIFOs are emptied, `ready` drops on the next cycle, and the block waits for new markers on every lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | frame clock |
| rst_n | input | 1 | active-low asynchronous reset |
| align_pulse | input | 1 | multiframe alignment reference |
| rbd | input | $clog2(K+1) | release offset in frames after a boundary |
| lane_valid | input | LANES | per-lane frame valid |
| lane_start | input | LANES | per-lane start-of-data marker |
| lane_data | input | LANES*DW | per-lane frame data, lane i at bits i*DW |
| out_data | output | LANES*DW | released frames, lane i at bits i*DW |
| ready | output | 1 | lanes released and streaming |
| last_arrival | output | $clog2(K) | counter value at last lane arrival |
| overflow | output | 1 | sticky FIFO overflow |
| align_err | output | 1 | sticky alignment phase mismatch |

## Verification
Take c as the cycle in which an input is driven; it is sampled at edge c+1. If the alignment pulse is in cycle n and the last marker in cycle s, then `last_arrival` equals (s-n-1) mod K from cycle s+1. `ready` and lane frame 0 appear in cycle e, the smallest e >= s+2 with (e-n-2) mod K equal to the release position. Frame j appears in cycle e+j. Both error flags and the flush show in the cycle after the offending sample. The bench drives on falling edges and compares on the next falling edge against those formulas. It sweeps every release offset against a range of lane skews and alignment-pulse phases.

// File: rtl/lane_release_buffer.sv
module lane_release_buffer #(
  parameter int LANES = 4,
  parameter int DW    = 16,
  parameter int K     = 32,
  parameter int DEPTH = 32,
  localparam int KW = $clog2(K + 1),
  localparam int MW = $clog2(K),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                align_pulse,
  input  logic [KW-1:0]       rbd,
  input  logic [LANES-1:0]    lane_valid,
  input  logic [LANES-1:0]    lane_start,
  input  logic [LANES*DW-1:0] lane_data,
  output logic [LANES*DW-1:0] out_data,
  output logic                ready,
  output logic [MW-1:0]       last_arrival,
  output logic                overflow,
  output logic                align_err
);

  logic [MW-1:0]    mf;
  logic             aligned;
  logic [LANES-1:0] armed;
  logic             all_in;
  logic [AW:0]      rd;
  logic [LANES-1:0] wr_en;
  logic [LANES-1:0] ovf_hit;

  wire [MW-1:0]    rel_pos  = (rbd == '0 || rbd >= KW'(K)) ? '0 : MW'(rbd);
  wire             mf_last  = (mf == MW'(K - 1));
  wire             flush    = |(armed & ~lane_valid);
  wire [LANES-1:0] armed_nx = armed | (lane_valid & lane_start);
  wire             arrive   = (&armed_nx) && !(&armed);
  wire             go       = aligned && all_in && !ready && (mf == rel_pos) && !flush;

  assign wr_en = lane_valid & armed_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mf        <= '0;
      aligned   <= 1'b0;
      align_err <= 1'b0;
    end else if (align_pulse && !aligned) begin
      mf      <= '0;
      aligned <= 1'b1;
    end else begin
      if (align_pulse && !mf_last) align_err <= 1'b1;
      mf <= mf_last ? '0 : mf + MW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed        <= '0;
      all_in       <= 1'b0;
      rd           <= '0;
      ready        <= 1'b0;
      last_arrival <= '0;
      overflow     <= 1'b0;
    end else if (flush) begin
      armed  <= '0;
      all_in <= 1'b0;
      rd     <= '0;
      ready  <= 1'b0;
    end else begin
      armed <= armed_nx;
      if (|ovf_hit) overflow <= 1'b1;
      if (arrive) begin
        all_in       <= 1'b1;
        last_arrival <= mf;
      end
      if (go) ready <= 1'b1;
      if (go || ready) rd <= rd + 1'b1;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [AW:0]   wr;
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] q;
    wire  [AW:0]   fill = wr - rd;
    wire           full = (fill == (AW+1)'(DEPTH));

    assign ovf_hit[g] = wr_en[g] && full;
    assign out_data[g*DW +: DW] = q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  wr <= '0;
      else if (flush)              wr <= '0;
      else if (wr_en[g] && !full)  wr <= wr + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (wr_en[g] && !full && !flush) mem[wr[AW-1:0]] <= lane_data[g*DW +: DW];
      if (go || ready) q <= mem[rd[AW-1:0]];
    end

    assert_fill_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= (AW+1)'(DEPTH));
  end

  assert_release_needs_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> aligned);
  assert_release_at_point_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(mf) == $past(rel_pos)) && $past(all_in));
  assert_counter_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mf <= MW'(K - 1));
  assert_no_overflow_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  assert_align_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |=> align_err);
  assert_flush_drops_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && flush) |=> !ready);

endmodule

// File: tb/lane_release_buffer_bench.sv
module lane_release_buffer_bench;
  localparam int LANES = 2, DW = 8, K = 8, DEPTH = 32;
  localparam int KW = $clog2(K + 1), MW = $clog2(K);

  logic clk = 0, rst_n = 0, align_pulse = 0;
  logic [KW-1:0] rbd = KW'(K);
  logic [LANES-1:0] lane_valid = '0, lane_start = '0;
  logic [LANES*DW-1:0] lane_data = '0, out_data;
  logic ready, overflow, align_err;
  logic [MW-1:0] last_arrival;

  int cyc = 0, errs = 0, checks = 0, seed = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lane_release_buffer #(.LANES(LANES), .DW(DW), .K(K), .DEPTH(DEPTH)) u_lane_release_buffer (
    .clk(clk), .rst_n(rst_n), .align_pulse(align_pulse), .rbd(rbd),
    .lane_valid(lane_valid), .lane_start(lane_start), .lane_data(lane_data),
    .out_data(out_data), .ready(ready), .last_arrival(last_arrival),
    .overflow(overflow), .align_err(align_err));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic int word(int lane, int j);
    return (lane * 97 + j * 13 + seed) & 255;
  endfunction

  task automatic do_reset();
    rst_n = 0; align_pulse = 0; lane_valid = '0; lane_start = '0; lane_data = '0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready", int'(ready), 0);
    chk("R1 overflow", int'(overflow), 0);
    chk("R1 align_err", int'(align_err), 0);
    chk("R1 last_arrival", int'(last_arrival), 0);
  endtask

  task automatic drive_lanes(int c, int s0, int s1);
    for (int l = 0; l < LANES; l++) begin
      int sl = (l == 0) ? s0 : s1;
      lane_valid[l] = (c >= sl);
      lane_start[l] = (c == sl);
      lane_data[l*DW +: DW] = (c >= sl) ? DW'(word(l, c - sl)) : '0;
    end
  endtask

  task automatic run_case(int d0, int d1, int r, int pa_off);
    int n, s0, s1, s, p, e, pa;
    bit err_exp;
    do_reset();
    seed = seed + 7;
    rbd = KW'(r);
    n = cyc; s0 = n + d0; s1 = n + d1; s = (s0 > s1) ? s0 : s1;
    p = (r >= 1 && r < K) ? r : 0;
    e = s + 2;
    while (((e - n - 2) % K) != p) e++;
    pa = (pa_off > 0) ? n + pa_off : -1;
    err_exp = (pa >= 0) && (((pa - n - 1) % K) != K - 1);
    for (int c = n; c <= e + 12; c++) begin
      if (c > n) begin
        chk("R3 ready timing", int'(ready), (c >= e) ? 1 : 0);
        if (c >= e)
          for (int l = 0; l < LANES; l++)
            chk("R4 lane data", int'(out_data[l*DW +: DW]), word(l, c - e));
        if (c >= s + 1) chk("R5 last_arrival", int'(last_arrival), (s - n - 1) % K);
        if (pa >= 0) chk("R7 align_err", int'(align_err), (c > pa && err_exp) ? 1 : 0);
      end
      align_pulse = (c == n) || (c == pa);
      drive_lanes(c, s0, s1);
      @(negedge clk);
    end
    chk("R6 no overflow in normal run", int'(overflow), 0);
  endtask

  initial begin
    #(200000 * 10);
    errs++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int n;
    // R3 R4 R5: every release offset against lane skews, lane 1 last or tied
    for (int r = 1; r <= K; r++)
      for (int d1 = 1; d1 <= 2 * K; d1++)
        run_case(1, d1, r, 0);
    // R3 R5: lane 0 arriving last; R3 out-of-range offsets act as K
    for (int r = 1; r <= K; r++) run_case(6, 2, r, 0);
    run_case(3, 4, 0, 0);
    run_case(3, 4, 15, 0);
    // R7: second alignment pulse at each phase
    for (int pa = 1; pa <= 2 * K; pa++) run_case(2, 3, 3, pa);

    // R8: flush after release, then wait for new markers
    run_case(1, 2, K, 0);
    lane_valid[1] = 1'b0;
    @(negedge clk);
    chk("R8 ready after valid drop", int'(ready), 0);
    lane_valid[1] = 1'b1;
    lane_start = '0;
    for (int i = 0; i < 2 * K; i++) begin
      @(negedge clk);
      chk("R8 waiting without markers", int'(ready), 0);
    end

    // R2: lanes present but no alignment pulse
    do_reset();
    n = cyc;
    for (int c = n; c < n + 3 * K; c++) begin
      if (c > n) chk("R2 no release before alignment", int'(ready), 0);
      drive_lanes(c, n + 1, n + 2);
      @(negedge clk);
    end

    // R6: lane 1 never arrives, lane 0 fills its FIFO
    do_reset();
    seed = seed + 7;
    rbd = KW'(K);
    n = cyc;
    for (int c = n; c <= n + DEPTH + 6; c++) begin
      if (c > n) chk("R6 overflow", int'(overflow), ((c - (n + 1)) > DEPTH) ? 1 : 0);
      align_pulse = (c == n);
      drive_lanes(c, n + 1, 1 << 30);
      @(negedge clk);
    end
    lane_valid[0] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R6 overflow sticky across flush", int'(overflow), 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule